// File: doc/BRIEF.md
# Paged DMA Buffer Address Generator

This block produces the byte address for a bus transfer whose buffer is contiguous to the software that owns it but is scattered over physical 4 KiB pages. A descriptor supplies seven page pointers of 20 bits each, an index naming the page the transfer starts in, and a 12-bit starting offset. On a load strobe the block forms the start address from the chosen pointer (upper bits) and the offset (lower bits). It also keeps a private copy of the pointer that follows the chosen one.

Each advance strobe moves the address forward by a byte count of 1 to 4. When the offset plus that count carries out of bit 11, the block does not add one to the page number. It drops in the held next pointer as the new page portion and keeps the low 12 bits of the sum as the new offset. All of this happens in the same cycle, so the transfer does not stall. The block then fetches the pointer after that one for the following crossing. A crossing with no pointer left raises a sticky error flag and freezes the address until the next load.

The descriptor pointers must stay on the input bus while a transfer runs. Load and advance are never asserted together. The step count is 1 to 4.

Top module: `pgaddr_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it, `addr_o` is 0 and `cross_o` and `err_o` are 0.
- R2: The cycle after a load with `pg_sel_i` in 0..6, `addr_o` equals pointer `pg_sel_i` (bits `[20*k+19:20*k]` of `page_ptrs_i` for pointer k) in bits 31:12, joined with `ofs_i` in bits 11:0. `err_o` is 0.
- R3: An advance whose offset plus `step_i` stays below 4096 adds `step_i` to `addr_o` and leaves bits 31:12 unchanged.
- R4: An advance whose offset plus `step_i` reaches 4096 or more sets bits 31:12 to the next pointer in the array and bits 11:0 to the sum minus 4096. This happens in the very next cycle.
- R5: Successive crossings walk the array in order: pointer k+1, then k+2, and so on, up to pointer 6.
- R6: `cross_o` is high for exactly one cycle, the cycle after each advance that replaced the page. It is low at all other times.
- R7: A crossing attempted while the current page is pointer 6 sets `err_o` and leaves `addr_o` unchanged. While `err_o` is high, advances have no effect on `addr_o`. A later valid load clears `err_o`.
- R8: A load with `pg_sel_i` equal to 7 sets `err_o` and gives `addr_o` a page portion of 0 with the loaded offset. Later advances leave `addr_o` unchanged.
- R9: A cycle with neither load nor advance leaves `addr_o` unchanged.
- R10: The first crossing after a load uses the next pointer as it was on `page_ptrs_i` at the load. A later change to that pointer on the bus does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Start a transfer from the descriptor fields |
| pg_sel_i | input | 3 | Index of the pointer holding the first page |
| ofs_i | input | 12 | Starting byte offset within the first page |
| page_ptrs_i | input | 140 | Seven 20-bit page pointers; pointer k is in bits 20k+19:20k |
| adv_i | input | 1 | Advance the address by `step_i` bytes |
| step_i | input | 3 | Bytes moved this beat, 1 to 4 |
| addr_o | output | 32 | Current physical byte address |
| cross_o | output | 1 | One-cycle pulse after a page replacement |
| err_o | output | 1 | Sticky flag: pointer array exhausted or invalid select |

## Verification
The hardest condition to reach is running off the end of the pointer array. A crossing happens only once every thousand or so beats, so reaching the fault takes two full page walks. The stimulus loads at pointer 4, close to the end of the page, and then drives long runs of 4-byte advances until page 6 fills and the next carry faults. The R10 case is also hard to see from the ports. To expose it, the bench rewrites the next pointer on the bus after the load and before the first carry.

// File: rtl/pgaddr_pkg.sv
// Package: shared geometry defaults and the per-cycle step classification
// used by the paged address generator.
package pgaddr_pkg;

    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_OFS_W   = 12;
    localparam int unsigned DEF_NUM_PTR = 7;
    localparam int unsigned DEF_STEP_W  = 3;

    // Outcome of one clock cycle as seen by the address state.
    typedef enum logic [1:0] {
        STEP_IDLE   = 2'd0,
        STEP_INPAGE = 2'd1,
        STEP_CROSS  = 2'd2,
        STEP_FAULT  = 2'd3
    } step_kind_e;

endpackage

// File: rtl/pgaddr_ptr_mux.sv
// Module: pgaddr_ptr_mux
// Picks one page pointer out of the flattened descriptor array.
// Assumes: pointer k is in bits [k*PAGE_W +: PAGE_W]. An index at or
// above NUM_PTR yields zero and drops ok_o.
module pgaddr_ptr_mux #(
    parameter int unsigned NUM_PTR = 7,
    parameter int unsigned PAGE_W  = 20,
    parameter int unsigned IDX_W   = 4
) (
    input  logic [NUM_PTR*PAGE_W-1:0] ptrs_i,
    input  logic [IDX_W-1:0]          idx_i,
    output logic [PAGE_W-1:0]         ptr_o,
    output logic                      ok_o
);

    logic [PAGE_W-1:0] ptr_arr [NUM_PTR];

    // Split the flat bus into one entry per pointer.
    for (genvar g = 0; g < NUM_PTR; g++) begin : g_unpack
        assign ptr_arr[g] = ptrs_i[g*PAGE_W +: PAGE_W];
    end

    // Select the indexed entry; out-of-range indices give zero.
    always_comb begin
        ptr_o = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (idx_i == IDX_W'(i)) begin
                ptr_o = ptr_arr[i];
            end
        end
    end

    // Flag whether the index names a real pointer.
    assign ok_o = (idx_i < IDX_W'(NUM_PTR));

endmodule

// File: rtl/pgaddr_ofs_step.sv
// Module: pgaddr_ofs_step
// Adds the beat byte count to the in-page offset and reports a carry out
// of the offset field, which marks a page crossing.
// Assumes: STEP_W < OFS_W.
module pgaddr_ofs_step #(
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned STEP_W = 3
) (
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [OFS_W-1:0]  ofs_o,
    output logic              carry_o
);

    localparam int unsigned SUM_W = OFS_W + 1;

    logic [SUM_W-1:0] sum;

    // Widen both operands and add; the top bit is the page carry.
    always_comb begin
        sum     = {1'b0, ofs_i} + SUM_W'(step_i);
        ofs_o   = sum[OFS_W-1:0];
        carry_o = sum[OFS_W];
    end

endmodule

// File: rtl/pgaddr_gen.sv
// Module: pgaddr_gen (top)
// Generates byte addresses over a buffer split across physical pages.
// A load latches the selected page pointer, the pointer after it and the
// start offset. Each advance adds step_i. A carry out of the offset
// swaps in the held next pointer in the same cycle, and the next pointer
// after that is fetched from the array.
// Assumes: page_ptrs_i is held for the whole transfer; load_i and adv_i
// are never high together; step_i is 1..4.
module pgaddr_gen #(
    parameter int unsigned ADDR_W  = pgaddr_pkg::DEF_ADDR_W,
    parameter int unsigned OFS_W   = pgaddr_pkg::DEF_OFS_W,
    parameter int unsigned NUM_PTR = pgaddr_pkg::DEF_NUM_PTR,
    parameter int unsigned STEP_W  = pgaddr_pkg::DEF_STEP_W,
    parameter int unsigned SEL_W   = $clog2(NUM_PTR + 1),
    parameter int unsigned PAGE_W  = ADDR_W - OFS_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [SEL_W-1:0]          pg_sel_i,
    input  logic [OFS_W-1:0]          ofs_i,
    input  logic [NUM_PTR*PAGE_W-1:0] page_ptrs_i,
    input  logic                      adv_i,
    input  logic [STEP_W-1:0]         step_i,
    output logic [ADDR_W-1:0]         addr_o,
    output logic                      cross_o,
    output logic                      err_o
);

    import pgaddr_pkg::*;

    localparam int unsigned IDX_W = SEL_W + 1;

    logic [PAGE_W-1:0] cur_page_q;
    logic [PAGE_W-1:0] nxt_page_q;
    logic              nxt_ok_q;
    logic [IDX_W-1:0]  nxt_idx_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              err_q;
    logic              cross_q;

    logic [IDX_W-1:0]  sel_idx;
    logic [IDX_W-1:0]  fetch_idx;
    logic [PAGE_W-1:0] sel_ptr;
    logic              sel_ok;
    logic [PAGE_W-1:0] fetch_ptr;
    logic              fetch_ok;
    logic [OFS_W-1:0]  ofs_sum;
    logic              ofs_carry;
    step_kind_e        kind;

    assign sel_idx = IDX_W'(pg_sel_i);

    // Next-pointer fetch index: after the selected one on load, else after the held one.
    assign fetch_idx = load_i ? (sel_idx + IDX_W'(1)) : (nxt_idx_q + IDX_W'(1));

    pgaddr_ptr_mux #(
        .NUM_PTR (NUM_PTR),
        .PAGE_W  (PAGE_W),
        .IDX_W   (IDX_W)
    ) u_sel_mux (
        .ptrs_i (page_ptrs_i),
        .idx_i  (sel_idx),
        .ptr_o  (sel_ptr),
        .ok_o   (sel_ok)
    );

    pgaddr_ptr_mux #(
        .NUM_PTR (NUM_PTR),
        .PAGE_W  (PAGE_W),
        .IDX_W   (IDX_W)
    ) u_fetch_mux (
        .ptrs_i (page_ptrs_i),
        .idx_i  (fetch_idx),
        .ptr_o  (fetch_ptr),
        .ok_o   (fetch_ok)
    );

    pgaddr_ofs_step #(
        .OFS_W  (OFS_W),
        .STEP_W (STEP_W)
    ) u_step (
        .ofs_i   (ofs_q),
        .step_i  (step_i),
        .ofs_o   (ofs_sum),
        .carry_o (ofs_carry)
    );

    // Classify this cycle's advance: ignored, in-page, page swap, or array exhausted.
    always_comb begin
        kind = STEP_IDLE;
        if (!load_i && adv_i && !err_q) begin
            if (!ofs_carry) begin
                kind = STEP_INPAGE;
            end else if (nxt_ok_q) begin
                kind = STEP_CROSS;
            end else begin
                kind = STEP_FAULT;
            end
        end
    end

    // Address state: load from the descriptor, or apply the classified step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_page_q <= '0;
            nxt_page_q <= '0;
            nxt_ok_q   <= 1'b0;
            nxt_idx_q  <= '0;
            ofs_q      <= '0;
            err_q      <= 1'b0;
            cross_q    <= 1'b0;
        end else if (load_i) begin
            cur_page_q <= sel_ptr;
            nxt_page_q <= fetch_ptr;
            nxt_ok_q   <= fetch_ok && sel_ok;
            nxt_idx_q  <= sel_idx + IDX_W'(1);
            ofs_q      <= ofs_i;
            err_q      <= !sel_ok;
            cross_q    <= 1'b0;
        end else begin
            cross_q <= 1'b0;
            unique case (kind)
                STEP_INPAGE: begin
                    ofs_q <= ofs_sum;
                end
                STEP_CROSS: begin
                    ofs_q      <= ofs_sum;
                    cur_page_q <= nxt_page_q;
                    nxt_page_q <= fetch_ptr;
                    nxt_ok_q   <= fetch_ok;
                    nxt_idx_q  <= nxt_idx_q + IDX_W'(1);
                    cross_q    <= 1'b1;
                end
                STEP_FAULT: begin
                    err_q <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    assign addr_o  = {cur_page_q, ofs_q};
    assign cross_o = cross_q;
    assign err_o   = err_q;

endmodule

// File: rtl/pgaddr_gen_chk.sv
// Module: pgaddr_gen_chk
// Port-level temporal checks for pgaddr_gen, attached by bind.
// Assumes the same stimulus rules as the top: step 1..4, no load with advance.
module pgaddr_gen_chk #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFS_W   = 12,
    parameter int unsigned NUM_PTR = 7,
    parameter int unsigned STEP_W  = 3,
    parameter int unsigned SEL_W   = 3,
    parameter int unsigned PAGE_W  = 20
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      load_i,
    input logic [SEL_W-1:0]          pg_sel_i,
    input logic [OFS_W-1:0]          ofs_i,
    input logic [NUM_PTR*PAGE_W-1:0] page_ptrs_i,
    input logic                      adv_i,
    input logic [STEP_W-1:0]         step_i,
    input logic [ADDR_W-1:0]         addr_o,
    input logic                      cross_o,
    input logic                      err_o
);

    logic [OFS_W:0] sum_c;

    // Offset-plus-step seen from the output address.
    assign sum_c = {1'b0, addr_o[OFS_W-1:0]} + (OFS_W+1)'(step_i);

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (32'(pg_sel_i) < NUM_PTR)) |=>
        (addr_o == {$past(page_ptrs_i[32'(pg_sel_i)*PAGE_W +: PAGE_W]), $past(ofs_i)})); // R2

    AST_INPAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && !err_o && !sum_c[OFS_W]) |=>
        (addr_o == {$past(addr_o[ADDR_W-1:OFS_W]), $past(sum_c[OFS_W-1:0])})); // R3

    AST_CROSS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cross_o |=> !cross_o); // R6

    AST_CROSS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cross_o |-> ($past(adv_i) && !$past(load_i))); // R6

    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !load_i) |=> (err_o && $stable(addr_o))); // R7

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (32'(pg_sel_i) < NUM_PTR)) |=> !err_o); // R7

    AST_BAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (32'(pg_sel_i) >= NUM_PTR)) |=> err_o); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(addr_o)); // R9

endmodule

bind pgaddr_gen pgaddr_gen_chk #(
    .ADDR_W  (ADDR_W),
    .OFS_W   (OFS_W),
    .NUM_PTR (NUM_PTR),
    .STEP_W  (STEP_W),
    .SEL_W   (SEL_W),
    .PAGE_W  (PAGE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .pg_sel_i    (pg_sel_i),
    .ofs_i       (ofs_i),
    .page_ptrs_i (page_ptrs_i),
    .adv_i       (adv_i),
    .step_i      (step_i),
    .addr_o      (addr_o),
    .cross_o     (cross_o),
    .err_o       (err_o)
);

// File: tb/pgaddr_gen_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated every clock and compared at
// each falling edge. Inputs change only at falling edges.
module pgaddr_gen_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [2:0]   pg_sel_i = '0;
    logic [11:0]  ofs_i = '0;
    logic [139:0] page_ptrs_i;
    logic         adv_i = 1'b0;
    logic [2:0]   step_i = 3'd1;
    logic [31:0]  addr_o;
    logic         cross_o;
    logic         err_o;

    int bp [7];
    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state.
    int m_page, m_ofs, m_idx, m_nxt;
    bit m_err, m_cross;

    always #5 clk = ~clk;

    // Pack the bench pointer table onto the descriptor bus.
    always_comb begin
        for (int k = 0; k < 7; k++) page_ptrs_i[k*20 +: 20] = bp[k][19:0];
    end

    pgaddr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .pg_sel_i(pg_sel_i),
        .ofs_i(ofs_i), .page_ptrs_i(page_ptrs_i), .adv_i(adv_i),
        .step_i(step_i), .addr_o(addr_o), .cross_o(cross_o), .err_o(err_o)
    );

    task automatic model_update(bit rst, bit ld, int sel, int ofs, bit adv, int stp);
        int s;
        if (rst) begin
            m_page = 0; m_ofs = 0; m_idx = 0; m_nxt = 0; m_err = 0; m_cross = 0;
        end else if (ld) begin
            m_page  = (sel < 7) ? bp[sel] : 0;
            m_err   = (sel >= 7);
            m_ofs   = ofs;
            m_idx   = sel;
            m_nxt   = (sel + 1 < 7) ? bp[sel+1] : 0;
            m_cross = 0;
        end else if (adv && !m_err) begin
            s = m_ofs + stp;
            m_cross = 0;
            if (s < 4096) m_ofs = s;
            else if (m_idx + 1 < 7) begin
                m_page  = m_nxt;
                m_idx   = m_idx + 1;
                m_nxt   = (m_idx + 1 < 7) ? bp[m_idx+1] : 0;
                m_ofs   = s - 4096;
                m_cross = 1;
            end else m_err = 1;
        end else m_cross = 0;
    endtask

    task automatic compare(string tag);
        logic [31:0] exp_addr;
        exp_addr = {m_page[19:0], m_ofs[11:0]};
        vectors++;
        if (addr_o !== exp_addr) begin
            fails++;
            $display("FAIL %s addr_o actual=%h expected=%h", tag, addr_o, exp_addr);
        end
        vectors++;
        if (cross_o !== m_cross) begin
            fails++;
            $display("FAIL %s cross_o actual=%b expected=%b", tag, cross_o, m_cross);
        end
        vectors++;
        if (err_o !== m_err) begin
            fails++;
            $display("FAIL %s err_o actual=%b expected=%b", tag, err_o, m_err);
        end
    endtask

    // One cycle: drive at the falling edge, model at the rising edge, compare at the next falling edge.
    task automatic apply(bit ld, int sel, int ofs, bit adv, int stp, string tag);
        load_i = ld; pg_sel_i = sel[2:0]; ofs_i = ofs[11:0];
        adv_i = adv; step_i = stp[2:0];
        @(posedge clk);
        model_update(!rst_n, ld, sel, ofs, adv, stp);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic adv_n(int n, int stp, string tag);
        for (int k = 0; k < n; k++) apply(0, 0, 0, 1, stp, tag);
    endtask

    initial begin
        for (int k = 0; k < 7; k++) bp[k] = 32'h3A000 + k * 32'h1111 + 5 * k;
        @(negedge clk);
        apply(0, 0, 0, 0, 1, "R1");
        apply(0, 0, 0, 1, 2, "R1");
        rst_n = 1'b1;
        apply(0, 0, 0, 0, 1, "R1");

        // R2 / R3: load and in-page steps of every size.
        apply(1, 0, 12'h100, 0, 1, "R2");
        apply(0, 0, 0, 1, 1, "R3");
        apply(0, 0, 0, 1, 2, "R3");
        apply(0, 0, 0, 1, 3, "R3");
        apply(0, 0, 0, 1, 4, "R3");
        // R9: idle cycles hold.
        apply(0, 0, 0, 0, 4, "R9");
        apply(0, 0, 0, 0, 1, "R9");

        // R4 / R6: exact boundary hit and overshoot.
        apply(1, 2, 12'hFFC, 0, 1, "R2");
        apply(0, 0, 0, 1, 4, "R4");
        apply(0, 0, 0, 0, 1, "R6");
        apply(1, 3, 12'hFFE, 0, 1, "R2");
        apply(0, 0, 0, 1, 3, "R4");
        apply(0, 0, 0, 1, 1, "R6");

        // R10: next pointer changed on the bus after the load.
        apply(1, 1, 12'hFFF, 0, 1, "R2");
        bp[2] = 32'h0BEEF;
        apply(0, 0, 0, 1, 1, "R10");
        bp[2] = 32'h3A000 + 2 * 32'h1111 + 10;

        // R5 / R7: walk pointers 4 -> 5 -> 6, then exhaust the array.
        apply(1, 4, 12'hFF0, 0, 1, "R2");
        adv_n(4, 4, "R5");
        adv_n(1024, 4, "R5");
        adv_n(1024, 4, "R7");
        adv_n(3, 2, "R7");
        apply(1, 0, 12'h010, 0, 1, "R7");
        apply(0, 0, 0, 1, 4, "R3");

        // R8: select beyond the array.
        apply(1, 7, 12'h234, 0, 1, "R8");
        adv_n(3, 4, "R8");
        apply(1, 6, 12'hFFD, 0, 1, "R2");
        apply(0, 0, 0, 1, 4, "R7");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule